// File: doc/BRIEF.md
# System Status Word Assembler

This block builds a single read-only status word for a low-power controller. Some bits in the word are live levels: the media-changed pin, the wake-up pin, mains adapter presence and the three modem-control lines. Others are sticky event flags: wake-from-standby, new battery, reset button, power fail and cold start. Each sticky flag has its own set source and its own clear rule. The word also carries a display-identification nibble, the count of a divide-by-64 prescaler on the 64 Hz tick, and the UART busy, receive-empty and transmit-full indications.

Software reads `status_o` at any time. Three write strobes clear flags, each a one-cycle pulse decoded elsewhere:
- a flag-clear strobe for the power and battery flags;
- a halt strobe, which clears the wake flag;
- a standby strobe, which also clears the wake flag.

The prescaler produces a one-cycle `rtc_inc_o` pulse once every 64 ticks. A real-time counter uses this pulse as its 1 Hz increment.

Every asynchronous pin passes through a two-flop synchronizer. Edge detection runs on the synchronized level. A live bit therefore follows its pin two clock edges later, and an edge-set flag rises one edge after that. The UART, LCD enable, standby, tick and strobe inputs are already synchronous and are used directly.

Top module: `sys_status_word`

## Requirements
- R1: Bit 0 shows the synchronized media-changed level and bit 2 the synchronized wake-up level. Bit 1 is the inverse of the synchronized active-low adapter-detect pin. Bits 8, 9 and 10 show the synchronized CTS, DSR and DCD levels.
- R2: Bit 3 (wake flag) sets on a rising edge of the synchronized wake-up pin while `standby_i` is high. A rising edge while `standby_i` is low leaves it untouched. It clears on a `wr_halt_i`, `wr_stdby_i` or `sys_rst_i` pulse. A flag-clear pulse does not touch it.
- R3: Bit 12 (new battery) sets on a rising edge of the synchronized battery-change pin. Only a `wr_flagclr_i` pulse clears it; halt and standby pulses and a falling pin do not.
- R4: Bit 13 sets while the synchronized `usr_rst_n_i` is low, and bit 14 sets while the synchronized `pwr_fail_i` is high. Both hold after the pin returns to idle, until a `wr_flagclr_i` pulse.
- R5: Bit 15 (cold start) is 1 after the power-on reset `rst_n`, and a `wr_flagclr_i` pulse clears it.
- R6: When a flag's set event and its clear pulse fall in the same cycle, the flag ends up set.
- R7: Bits 7:4 follow the synchronized `lcd_data_i` while `lcd_en_i` is low. While `lcd_en_i` is high they hold the last value taken before enable rose.
- R8: Each `tick64_i` pulse advances a 6-bit prescaler count by one, modulo 64. Bits 21:16 show that count bit-reversed, so count bit 0 (the 32 Hz stage) sits at bit 21 and count bit 5 (the 1 Hz stage) at bit 16. Without a tick the field is unchanged.
- R9: `rtc_inc_o` is high for exactly the one cycle after the tick that wraps the count from 63 to 0, so once per 64 ticks.
- R10: Bit 22 is `rx_fifo_empty_i` when `fifo_en_i` is 1 and `rx_hold_empty_i` otherwise. Bit 23 is `tx_fifo_full_i` when `fifo_en_i` is 1 and `tx_hold_full_i` otherwise.
- R11: Bit 11 is the current `uart_busy_i` level; bits 31:24 are 0.
- R12: After power-on reset with idle pins (adapter-detect and user-reset high, the rest low), the word is 0x0000_8000 plus the bit 22/23 values that R10 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_i | input | 1 | System-reset pulse, clears wake flag |
| standby_i | input | 1 | High while the system is in standby |
| wr_flagclr_i | input | 1 | Flag-clear write strobe |
| wr_halt_i | input | 1 | Halt write strobe |
| wr_stdby_i | input | 1 | Standby write strobe |
| media_chg_i | input | 1 | Media-changed pin (async) |
| adapter_n_i | input | 1 | Active-low adapter-detect pin (async) |
| wake_i | input | 1 | Wake-up pin (async) |
| bat_chg_i | input | 1 | Battery-change pin (async) |
| usr_rst_n_i | input | 1 | Active-low reset-button pin (async) |
| pwr_fail_i | input | 1 | Power-fail pin (async) |
| lcd_data_i | input | 4 | LCD data lines (async) |
| lcd_en_i | input | 1 | LCD enable control bit |
| cts_i | input | 1 | Clear-to-send line (async) |
| dsr_i | input | 1 | Data-set-ready line (async) |
| dcd_i | input | 1 | Carrier-detect line (async) |
| uart_busy_i | input | 1 | UART transmitter busy |
| fifo_en_i | input | 1 | UART FIFO enable |
| rx_fifo_empty_i | input | 1 | Receive FIFO empty |
| rx_hold_empty_i | input | 1 | Receive holding register empty |
| tx_fifo_full_i | input | 1 | Transmit FIFO full |
| tx_hold_full_i | input | 1 | Transmit holding register full |
| tick64_i | input | 1 | 64 Hz tick, one-cycle pulse |
| status_o | output | 32 | Assembled status word |
| rtc_inc_o | output | 1 | 1 Hz increment pulse |

## Verification
A sticky flag's set event can land in the same cycle as the strobe that clears it. The bench provokes this by raising a pin and timing the strobe into the third cycle, where the synchronized edge has just appeared. The wake flag is driven against a halt strobe, the battery flag against a flag-clear strobe, and the level-set reset and power-fail flags against a clear while their pins stay asserted. In every case the flag is expected to read 1 on the next sample, and a later lone strobe is expected to clear it.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
  localparam int unsigned ID_W     = 4;
  localparam int unsigned DIV_W    = 6;
  localparam int unsigned STATUS_W = 32;

  // status word bit positions
  localparam int unsigned B_MEDIA = 0;
  localparam int unsigned B_ADAPT = 1;
  localparam int unsigned B_WAKEL = 2;
  localparam int unsigned B_WAKEF = 3;
  localparam int unsigned B_ID    = 4;
  localparam int unsigned B_CTS   = B_ID + ID_W;
  localparam int unsigned B_DSR   = B_CTS + 1;
  localparam int unsigned B_DCD   = B_CTS + 2;
  localparam int unsigned B_BUSY  = B_CTS + 3;
  localparam int unsigned B_NBAT  = B_CTS + 4;
  localparam int unsigned B_RSTF  = B_CTS + 5;
  localparam int unsigned B_PFF   = B_CTS + 6;
  localparam int unsigned B_COLD  = B_CTS + 7;
  localparam int unsigned B_DIV   = B_COLD + 1;
  localparam int unsigned B_RXE   = B_DIV + DIV_W;
  localparam int unsigned B_TXF   = B_RXE + 1;

  // synchronizer lane indices
  localparam int unsigned S_CTS   = 0;
  localparam int unsigned S_DSR   = 1;
  localparam int unsigned S_DCD   = 2;
  localparam int unsigned S_MEDIA = 3;
  localparam int unsigned S_ADAPT = 4;
  localparam int unsigned S_WAKE  = 5;
  localparam int unsigned S_BAT   = 6;
  localparam int unsigned S_URST  = 7;
  localparam int unsigned S_PF    = 8;
  localparam int unsigned S_LCD   = 9;
  localparam int unsigned SYNC_N  = S_LCD + ID_W;

  localparam logic [SYNC_N-1:0] SYNC_IDLE = SYNC_N'((1 << S_ADAPT) | (1 << S_URST));

  // sticky flag indices
  localparam int unsigned F_WAKE = 0;
  localparam int unsigned F_NBAT = 1;
  localparam int unsigned F_RSTF = 2;
  localparam int unsigned F_PFF  = 3;
  localparam int unsigned F_COLD = 4;
  localparam int unsigned FLAG_N = 5;

  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1 << F_COLD);
endpackage

// File: rtl/sstat_sync.sv
module sstat_sync #(
  parameter int unsigned      N       = 1,
  parameter logic [N-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/sstat_sticky.sv
module sstat_sticky #(
  parameter int unsigned      N       = 1,
  parameter logic [N-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= RST_VAL[g];
      else if (set_i[g])  flag_q <= 1'b1;   // set has priority
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign q_o[g] = flag_q;
  end
endmodule

// File: rtl/sstat_prescale.sv
module sstat_prescale #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] rev_o,
  output logic         inc_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inc_o <= 1'b0;
    end else begin
      inc_o <= tick_i && (cnt_q == CNT_MAX);
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev_o[W-1-g] = cnt_q[g];
  end
endmodule

// File: rtl/sys_status_word.sv
module sys_status_word
  import sstat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_rst_i,
  input  logic                standby_i,
  input  logic                wr_flagclr_i,
  input  logic                wr_halt_i,
  input  logic                wr_stdby_i,
  input  logic                media_chg_i,
  input  logic                adapter_n_i,
  input  logic                wake_i,
  input  logic                bat_chg_i,
  input  logic                usr_rst_n_i,
  input  logic                pwr_fail_i,
  input  logic [ID_W-1:0]     lcd_data_i,
  input  logic                lcd_en_i,
  input  logic                cts_i,
  input  logic                dsr_i,
  input  logic                dcd_i,
  input  logic                uart_busy_i,
  input  logic                fifo_en_i,
  input  logic                rx_fifo_empty_i,
  input  logic                rx_hold_empty_i,
  input  logic                tx_fifo_full_i,
  input  logic                tx_hold_full_i,
  input  logic                tick64_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                rtc_inc_o
);
  logic [SYNC_N-1:0] pins_raw, pins_s;
  logic              wake_q, bat_q;
  logic              wake_rise, bat_rise;
  logic [FLAG_N-1:0] flag_set, flag_clr, flags;
  logic [ID_W-1:0]   disp_id_q;
  logic [DIV_W-1:0]  div_rev;

  assign pins_raw = {lcd_data_i, pwr_fail_i, usr_rst_n_i, bat_chg_i, wake_i,
                     adapter_n_i, media_chg_i, dcd_i, dsr_i, cts_i};

  sstat_sync #(.N(SYNC_N), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  // edge detection on synchronized levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      bat_q  <= 1'b0;
    end else begin
      wake_q <= pins_s[S_WAKE];
      bat_q  <= pins_s[S_BAT];
    end
  end
  assign wake_rise = pins_s[S_WAKE] & ~wake_q;
  assign bat_rise  = pins_s[S_BAT]  & ~bat_q;

  always_comb begin
    flag_set         = '0;
    flag_clr         = '0;
    flag_set[F_WAKE] = wake_rise & standby_i;
    flag_clr[F_WAKE] = wr_halt_i | wr_stdby_i | sys_rst_i;
    flag_set[F_NBAT] = bat_rise;
    flag_clr[F_NBAT] = wr_flagclr_i;
    flag_set[F_RSTF] = ~pins_s[S_URST];
    flag_clr[F_RSTF] = wr_flagclr_i;
    flag_set[F_PFF]  = pins_s[S_PF];
    flag_clr[F_PFF]  = wr_flagclr_i;
    flag_clr[F_COLD] = wr_flagclr_i;
  end

  sstat_sticky #(.N(FLAG_N), .RST_VAL(FLAG_RST)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flags)
  );

  // display id: transparent while LCD disabled, frozen while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         disp_id_q <= '0;
    else if (!lcd_en_i) disp_id_q <= pins_s[S_LCD +: ID_W];
  end

  sstat_prescale #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick64_i),
    .rev_o  (div_rev),
    .inc_o  (rtc_inc_o)
  );

  always_comb begin
    status_o                  = '0;
    status_o[B_MEDIA]         = pins_s[S_MEDIA];
    status_o[B_ADAPT]         = ~pins_s[S_ADAPT];
    status_o[B_WAKEL]         = pins_s[S_WAKE];
    status_o[B_WAKEF]         = flags[F_WAKE];
    status_o[B_ID +: ID_W]    = disp_id_q;
    status_o[B_CTS]           = pins_s[S_CTS];
    status_o[B_DSR]           = pins_s[S_DSR];
    status_o[B_DCD]           = pins_s[S_DCD];
    status_o[B_BUSY]          = uart_busy_i;
    status_o[B_NBAT]          = flags[F_NBAT];
    status_o[B_RSTF]          = flags[F_RSTF];
    status_o[B_PFF]           = flags[F_PFF];
    status_o[B_COLD]          = flags[F_COLD];
    status_o[B_DIV +: DIV_W]  = div_rev;
    status_o[B_RXE]           = fifo_en_i ? rx_fifo_empty_i : rx_hold_empty_i;
    status_o[B_TXF]           = fifo_en_i ? tx_fifo_full_i  : tx_hold_full_i;
  end
endmodule

// File: rtl/sys_status_chk.sv
module sys_status_chk
  import sstat_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                standby_i,
  input logic                wr_flagclr_i,
  input logic                wr_halt_i,
  input logic                wr_stdby_i,
  input logic                sys_rst_i,
  input logic                lcd_en_i,
  input logic                tick64_i,
  input logic [STATUS_W-1:0] status_i,
  input logic                rtc_inc_i
);
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_halt_i || wr_stdby_i || sys_rst_i) && !standby_i |=> !status_i[B_WAKEF]); // R2
  AST_NBAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_i[B_NBAT] && !wr_flagclr_i |=> status_i[B_NBAT]); // R3
  AST_RSTF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_i[B_RSTF] && !wr_flagclr_i |=> status_i[B_RSTF]); // R4
  AST_PFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status_i[B_PFF] && !wr_flagclr_i |=> status_i[B_PFF]); // R4
  AST_COLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flagclr_i |=> !status_i[B_COLD]); // R5
  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en_i |=> $stable(status_i[B_ID +: ID_W])); // R7
  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick64_i |=> $stable(status_i[B_DIV +: DIV_W])); // R8
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_inc_i |-> status_i[B_DIV +: DIV_W] == '0); // R9
  AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_inc_i |=> !rtc_inc_i); // R9
endmodule

bind sys_status_word sys_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby_i    (standby_i),
  .wr_flagclr_i (wr_flagclr_i),
  .wr_halt_i    (wr_halt_i),
  .wr_stdby_i   (wr_stdby_i),
  .sys_rst_i    (sys_rst_i),
  .lcd_en_i     (lcd_en_i),
  .tick64_i     (tick64_i),
  .status_i     (status_o),
  .rtc_inc_i    (rtc_inc_o)
);

// File: tb/sys_status_word_bench.sv
`timescale 1ns/1ps
module sys_status_word_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sys_rst_i, standby_i, wr_flagclr_i, wr_halt_i, wr_stdby_i;
  logic media_chg_i, adapter_n_i, wake_i, bat_chg_i, usr_rst_n_i, pwr_fail_i;
  logic [3:0] lcd_data_i;
  logic lcd_en_i, cts_i, dsr_i, dcd_i, uart_busy_i, fifo_en_i;
  logic rx_fifo_empty_i, rx_hold_empty_i, tx_fifo_full_i, tx_hold_full_i, tick64_i;
  logic [31:0] status_o;
  logic rtc_inc_o;

  sys_status_word u_sys_status_word (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  logic m_wakef, m_nbat, m_rstf, m_pff, m_cold;
  logic [3:0] m_id;
  logic [5:0] m_cnt;

  function automatic logic [5:0] rev6(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[5-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] expw();
    logic [31:0] w = '0;
    w[0]     = media_chg_i;
    w[1]     = ~adapter_n_i;
    w[2]     = wake_i;
    w[3]     = m_wakef;
    w[7:4]   = m_id;
    w[8]     = cts_i;
    w[9]     = dsr_i;
    w[10]    = dcd_i;
    w[11]    = uart_busy_i;
    w[12]    = m_nbat;
    w[13]    = m_rstf;
    w[14]    = m_pff;
    w[15]    = m_cold;
    w[21:16] = rev6(m_cnt);
    w[22]    = fifo_en_i ? rx_fifo_empty_i : rx_hold_empty_i;
    w[23]    = fifo_en_i ? tx_fifo_full_i : tx_hold_full_i;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
  endtask

  // which: 0 flagclr, 1 halt, 2 standby, 3 sys reset
  task automatic strobe(input int which);
    @(posedge clk); #1;
    case (which)
      0: wr_flagclr_i = 1'b1;
      1: wr_halt_i    = 1'b1;
      2: wr_stdby_i   = 1'b1;
      default: sys_rst_i = 1'b1;
    endcase
    @(posedge clk); #1;
    wr_flagclr_i = 1'b0; wr_halt_i = 1'b0; wr_stdby_i = 1'b0; sys_rst_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(posedge clk); #1;
    tick64_i = 1'b1;
    @(posedge clk); #1;
    tick64_i = 1'b0;
    m_cnt = m_cnt + 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sys_rst_i = 0; standby_i = 0; wr_flagclr_i = 0; wr_halt_i = 0; wr_stdby_i = 0;
    media_chg_i = 0; adapter_n_i = 1; wake_i = 0; bat_chg_i = 0; usr_rst_n_i = 1; pwr_fail_i = 0;
    lcd_data_i = 0; lcd_en_i = 0; cts_i = 0; dsr_i = 0; dcd_i = 0; uart_busy_i = 0; fifo_en_i = 0;
    rx_fifo_empty_i = 0; rx_hold_empty_i = 0; tx_fifo_full_i = 0; tx_hold_full_i = 0; tick64_i = 0;
    m_wakef = 0; m_nbat = 0; m_rstf = 0; m_pff = 0; m_cold = 1; m_id = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R12 reset word", status_o, 32'h0000_8000);
    chk("R9 no pulse after reset", {31'b0, rtc_inc_o}, 32'b0);

    strobe(0); m_cold = 0;
    chk("R5 cold flag cleared", status_o, expw());

    // R1 R10 R11 sweep; wake edges outside standby must not set the flag (R2)
    for (int i = 0; i < 4096; i++) begin
      @(posedge clk); #1;
      {media_chg_i, adapter_n_i, wake_i, cts_i, dsr_i, dcd_i} = i[11:6];
      {uart_busy_i, fifo_en_i, rx_fifo_empty_i, rx_hold_empty_i, tx_fifo_full_i, tx_hold_full_i} = i[5:0];
      settle();
      chk("R1 R2 R10 R11 sweep", status_o, expw());
    end
    @(posedge clk); #1;
    media_chg_i = 0; adapter_n_i = 1; wake_i = 0; cts_i = 0; dsr_i = 0; dcd_i = 0;
    settle();

    // R7 display id
    for (int v = 0; v < 16; v++) begin
      lcd_data_i = 4'(v); settle(); m_id = 4'(v);
      chk("R7 id follows", status_o, expw());
    end
    lcd_data_i = 4'h9; settle(); m_id = 4'h9;
    @(posedge clk); #1 lcd_en_i = 1;
    for (int v = 0; v < 16; v++) begin
      lcd_data_i = 4'(v); settle();
      chk("R7 id frozen", status_o, expw());
    end
    lcd_data_i = 4'h6; settle();
    @(posedge clk); #1 lcd_en_i = 0;
    settle(); m_id = 4'h6;
    chk("R7 id resumes", status_o, expw());

    // R2 wake flag
    standby_i = 1;
    for (int s = 1; s <= 3; s++) begin
      wake_i = 1; settle(); m_wakef = 1;
      chk("R2 wake set in standby", status_o, expw());
      if (s == 1) begin
        strobe(0);
        chk("R2 flagclr ignored by wake", status_o, expw());
      end
      wake_i = 0; settle();
      strobe(s); m_wakef = 0;
      chk("R2 wake cleared", status_o, expw());
    end
    // R6 wake edge collides with halt strobe
    @(posedge clk); #1 wake_i = 1;
    @(posedge clk); @(posedge clk); #1 wr_halt_i = 1;
    @(posedge clk); #1 wr_halt_i = 0; m_wakef = 1;
    @(negedge clk);
    chk("R6 wake set beats halt", status_o, expw());
    strobe(1); m_wakef = 0;
    chk("R2 wake cleared after collision", status_o, expw());
    wake_i = 0; standby_i = 0; settle();

    // R3 battery flag
    bat_chg_i = 1; settle(); m_nbat = 1;
    chk("R3 battery set", status_o, expw());
    strobe(1); strobe(2); strobe(3);
    chk("R3 halt/stdby ignored", status_o, expw());
    bat_chg_i = 0; settle();
    chk("R3 fall ignored", status_o, expw());
    strobe(0); m_nbat = 0;
    chk("R3 battery cleared", status_o, expw());
    @(posedge clk); #1 bat_chg_i = 1;
    @(posedge clk); @(posedge clk); #1 wr_flagclr_i = 1;
    @(posedge clk); #1 wr_flagclr_i = 0; m_nbat = 1;
    @(negedge clk);
    chk("R6 battery set beats clear", status_o, expw());
    strobe(0); m_nbat = 0;
    chk("R3 battery cleared again", status_o, expw());
    bat_chg_i = 0; settle();

    // R4 reset-button and power-fail flags
    usr_rst_n_i = 0; settle(); m_rstf = 1;
    chk("R4 reset flag set", status_o, expw());
    strobe(0);
    chk("R6 reset flag held while pin low", status_o, expw());
    usr_rst_n_i = 1; settle();
    chk("R4 reset flag sticky", status_o, expw());
    strobe(0); m_rstf = 0;
    chk("R4 reset flag cleared", status_o, expw());
    pwr_fail_i = 1; settle(); m_pff = 1;
    chk("R4 power-fail flag set", status_o, expw());
    strobe(0);
    chk("R6 power-fail held while pin high", status_o, expw());
    pwr_fail_i = 0; settle();
    chk("R4 power-fail sticky", status_o, expw());
    strobe(0); m_pff = 0;
    chk("R4 power-fail cleared", status_o, expw());

    // R8 R9 prescaler
    begin
      int incs = 0;
      for (int k = 1; k <= 130; k++) begin
        tick_once();
        chk("R8 prescaler field", status_o, expw());
        chk("R9 increment pulse", {31'b0, rtc_inc_o}, {31'b0, m_cnt == 6'd0});
        if (rtc_inc_o) incs++;
        if (k % 5 == 0) begin
          settle();
          chk("R8 field holds without tick", status_o, expw());
          chk("R9 no pulse without tick", {31'b0, rtc_inc_o}, 32'b0);
        end
      end
      chk("R9 pulse count", 32'(incs), 32'd2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule